// File: doc/BRIEF.md
# Paced Burst Copy Engine with Host Lockout

This block moves a block of words from a shared on-chip word RAM into a transmit FIFO. A command strobe, active low, is lowered while a transfer is being set up and raised to launch it. On the rising transition the engine captures a start address and a word count. It then reads the RAM one word at a time at a fixed rate of one word per microsecond and pushes each word into the FIFO, so the outgoing block is staged as one contiguous run.

The host subsystem shares the RAM with this engine. It is kept away from the RAM from the moment the strobe is seen low until the burst has finished. A burst cannot be cut short: once launched, every requested word is copied. A strobe cycle that arrives while a burst runs is discarded. A single-cycle completion pulse marks the end of the burst, and the host lock drops in that same cycle.

The microsecond rate comes from a prescaler of `TICK_CYCLES` clock cycles, so the pacing stays exact at any clock frequency.

Top module: `burst_copy_dma`

## Requirements
- R1: After reset, `hostLock`, `burstDone`, `ramRdEn` and `fifoWrEn` are all low.
- R2: A burst is launched only by the low-to-high transition of `cmdStrobeN`. While the strobe is held low and no burst runs, `ramRdEn` stays low however long the strobe is held.
- R3: `hostLock` is high from the cycle after `cmdStrobeN` is sampled low, and it stays high in every cycle of a running burst.
- R4: A `wordCount` of 1 to 31 produces exactly that many FIFO writes. A `wordCount` of 0 produces exactly 32 (`MAX_WORDS`).
- R5: The k-th read of a burst (k counted from 0) uses address `baseAddr + k` modulo 2^`ADDR_W`. The k-th FIFO write carries the data the RAM returned for that read.
- R6: The first RAM read is issued in the cycle after the clock edge that samples the strobe high. Consecutive reads are exactly `TICK_CYCLES` cycles apart.
- R7: Each FIFO write occurs exactly one cycle after its RAM read, which matches a RAM with one cycle of read latency.
- R8: `burstDone` is high for exactly one cycle, in the cycle after the last FIFO write. In that cycle `hostLock` is low, provided the strobe is high.
- R9: A strobe low/high cycle during a running burst is ignored. It causes no extra reads or writes, and no second burst follows.
- R10: `wordCount` and `baseAddr` are sampled only at launch. Changing them during a burst has no effect on the burst's addresses, data or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStrobeN | input | 1 | Command strobe, active low; its rising edge launches a burst |
| wordCount | input | 5 | Words to copy; 0 means 32 |
| baseAddr | input | ADDR_W | First RAM address of the block |
| ramRdEn | output | 1 | RAM read request |
| ramRdAddr | output | ADDR_W | RAM read address |
| ramRdData | input | DATA_W | RAM read data, valid one cycle after `ramRdEn` |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | DATA_W | FIFO write data |
| hostLock | output | 1 | Host must not access the shared RAM while high |
| burstDone | output | 1 | One-cycle pulse when a burst completes |

## Verification
The bench builds the block with `TICK_CYCLES` = 5 instead of the 1 µs default. This keeps a full 32-word burst to about 160 cycles, so many bursts, including maximum-length ones, fit into a short run while the spacing between reads is still checked exactly. `ADDR_W` = 6 shrinks the RAM to 64 words, so random start addresses near the top often wrap to address 0 mid-burst. `DATA_W` = 16 lets each address return a distinct computed word, so any misplaced read shows up in the data.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dmaState_e;

  typedef struct packed {
    logic load;       // capture count and address, restart the prescaler
    logic issueRead;  // present one RAM read this cycle
    logic writeWord;  // push returned RAM word into the FIFO
  } dmaStrobe_t;

endpackage

// File: rtl/burst_dma_path.sv
module burst_dma_path
  import burst_dma_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int MAX_WORDS   = 32,
  parameter int TICK_CYCLES = 250,
  localparam int CNT_W  = $clog2(MAX_WORDS),
  localparam int REM_W  = CNT_W + 1,
  localparam int TICK_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strb,
  input  logic              busy,
  input  logic              hostLock,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [ADDR_W-1:0] ramRdAddr,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              tickZero,
  output logic              readsLeft
);

  logic [ADDR_W-1:0] addrQ;
  logic [REM_W-1:0]  remainQ;
  logic [TICK_W-1:0] tickQ;
  logic [REM_W-1:0]  loadCount;

  // a zero count stands for the largest burst
  always_comb begin
    if (wordCount == '0) loadCount = REM_W'(MAX_WORDS);
    else                 loadCount = {1'b0, wordCount};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      remainQ <= '0;
    end else if (strb.load) begin
      addrQ   <= baseAddr;
      remainQ <= loadCount;
    end else if (strb.issueRead) begin
      addrQ   <= addrQ + 1'b1;
      remainQ <= remainQ - 1'b1;
    end
  end

  // microsecond prescaler, restarted at each launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                tickQ <= '0;
    else if (strb.load || !busy)              tickQ <= '0;
    else if (tickQ == TICK_W'(TICK_CYCLES-1)) tickQ <= '0;
    else                                      tickQ <= tickQ + 1'b1;
  end

  assign tickZero   = (tickQ == '0);
  assign readsLeft  = (remainQ != '0);
  assign ramRdAddr  = addrQ;
  assign fifoWrData = ramRdData;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    strb.issueRead |-> remainQ != '0);                                   // R4
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.issueRead && !strb.load) |=> $stable(addrQ));         // R10
  AST_LOCK_ON_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issueRead || strb.writeWord) |-> hostLock);                    // R3

endmodule

// File: rtl/burst_dma_ctrl.sv
module burst_dma_ctrl
  import burst_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdStrobeN,
  input  logic       tickZero,
  input  logic       readsLeft,
  output dmaStrobe_t strb,
  output logic       busy,
  output logic       burstDone,
  output logic       hostLock
);

  dmaState_e stateQ;
  logic strobeQ;
  logic wrPendQ;
  logic doneQ;
  logic startEdge;
  logic issueRead;
  logic finish;

  // launch only on a low-to-high strobe seen while idle
  assign startEdge = (stateQ == ST_IDLE) && !strobeQ && cmdStrobeN;
  assign issueRead = (stateQ == ST_RUN) && tickZero && readsLeft;
  assign finish    = (stateQ == ST_RUN) && wrPendQ && !readsLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      strobeQ <= 1'b1;
      wrPendQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      strobeQ <= cmdStrobeN;
      wrPendQ <= issueRead;
      doneQ   <= finish;
      if (startEdge)   stateQ <= ST_RUN;
      else if (finish) stateQ <= ST_IDLE;
    end
  end

  assign strb.load      = startEdge;
  assign strb.issueRead = issueRead;
  assign strb.writeWord = wrPendQ;

  assign busy      = (stateQ == ST_RUN);
  assign burstDone = doneQ;
  assign hostLock  = busy || !strobeQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);                                           // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> $past(strb.writeWord) && !busy);                       // R8

endmodule

// File: rtl/burst_copy_dma.sv
module burst_copy_dma
  import burst_dma_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int MAX_WORDS   = 32,
  parameter int TICK_CYCLES = 250,
  localparam int CNT_W = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStrobeN,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              ramRdEn,
  output logic [ADDR_W-1:0] ramRdAddr,
  input  logic [DATA_W-1:0] ramRdData,
  output logic              fifoWrEn,
  output logic [DATA_W-1:0] fifoWrData,
  output logic              hostLock,
  output logic              burstDone
);

  dmaStrobe_t strb;
  logic busy;
  logic tickZero;
  logic readsLeft;

  burst_dma_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdStrobeN (cmdStrobeN),
    .tickZero   (tickZero),
    .readsLeft  (readsLeft),
    .strb       (strb),
    .busy       (busy),
    .burstDone  (burstDone),
    .hostLock   (hostLock)
  );

  burst_dma_path #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .MAX_WORDS   (MAX_WORDS),
    .TICK_CYCLES (TICK_CYCLES)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .busy       (busy),
    .hostLock   (hostLock),
    .wordCount  (wordCount),
    .baseAddr   (baseAddr),
    .ramRdData  (ramRdData),
    .ramRdAddr  (ramRdAddr),
    .fifoWrData (fifoWrData),
    .tickZero   (tickZero),
    .readsLeft  (readsLeft)
  );

  assign ramRdEn  = strb.issueRead;
  assign fifoWrEn = strb.writeWord;

  AST_READ_GAP: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |=> !ramRdEn);                                               // R6

endmodule

// File: tb/test_burst_copy_dma.sv
module test_burst_copy_dma;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;
  localparam int MAXW   = 32;
  localparam int TICK   = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdStrobeN = 1'b1;
  logic [4:0]        wordCount = '0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              ramRdEn;
  logic [ADDR_W-1:0] ramRdAddr;
  logic [DATA_W-1:0] ramRdData = '0;
  logic              fifoWrEn;
  logic [DATA_W-1:0] fifoWrData;
  logic              hostLock;
  logic              burstDone;

  int tests = 0;
  int fails = 0;
  int cycleCnt = 0;
  bit finished = 1'b0;

  int rdCnt = 0;
  int wrCnt = 0;
  int doneCnt = 0;
  int rdCyc [256];
  int wrCyc [256];
  logic [DATA_W-1:0] wrDat [256];
  int doneCyc = 0;
  logic doneLock = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  burst_copy_dma #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .MAX_WORDS (MAXW), .TICK_CYCLES (TICK)
  ) i_burst_copy_dma (
    .clk (clk), .rstN (rstN), .cmdStrobeN (cmdStrobeN), .wordCount (wordCount),
    .baseAddr (baseAddr), .ramRdEn (ramRdEn), .ramRdAddr (ramRdAddr),
    .ramRdData (ramRdData), .fifoWrEn (fifoWrEn), .fifoWrData (fifoWrData),
    .hostLock (hostLock), .burstDone (burstDone)
  );

  function automatic logic [DATA_W-1:0] ramWord(input int a);
    return DATA_W'((a * 40503 + 7) ^ 16'h5A3C);
  endfunction

  function automatic int effCount(input int n);
    return (n == 0) ? MAXW : n;
  endfunction

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (ramRdEn) ramRdData <= ramWord(int'(ramRdAddr));
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (ramRdEn) begin rdCyc[rdCnt % 256] = cycleCnt; rdCnt = rdCnt + 1; end
      if (fifoWrEn) begin
        wrCyc[wrCnt % 256] = cycleCnt; wrDat[wrCnt % 256] = fifoWrData; wrCnt = wrCnt + 1;
      end
      if (burstDone) begin doneCyc = cycleCnt; doneLock = hostLock; doneCnt = doneCnt + 1; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runBurst(input int n, input int base, input int hold, input bit disturb);
    int r0, w0, d0, c0, effN, okAll;
    r0 = rdCnt; w0 = wrCnt; d0 = doneCnt;
    effN = effCount(n);
    @(negedge clk);
    wordCount = 5'(n); baseAddr = ADDR_W'(base); cmdStrobeN = 1'b0;
    repeat (hold) @(negedge clk);
    check(hostLock == 1'b1, "R3 lock while strobe low", int'(hostLock), 1);
    check(rdCnt == r0, "R2 no read before rising edge", rdCnt - r0, 0);
    cmdStrobeN = 1'b1;
    c0 = cycleCnt + 1;
    @(negedge clk);
    check(hostLock == 1'b1, "R3 lock at launch", int'(hostLock), 1);
    if (disturb) begin
      repeat (TICK + 1) @(negedge clk);
      wordCount = 5'(n + 7); baseAddr = ADDR_W'(base + 13);  // R10 late change
      cmdStrobeN = 1'b0;                                      // R9 stray strobe
      repeat (2) @(negedge clk);
      check(hostLock == 1'b1, "R3 lock mid burst", int'(hostLock), 1);
      cmdStrobeN = 1'b1;
    end
    repeat (effN * TICK + 12) @(negedge clk);
    check(wrCnt - w0 == effN, disturb ? "R9 R10 write count" : "R4 write count", wrCnt - w0, effN);
    check(rdCnt - r0 == effN, "R4 read count", rdCnt - r0, effN);
    okAll = 1;
    for (int i = 0; i < effN && i < rdCnt - r0; i++) begin
      int idx;
      idx = (r0 + i) % 256;
      if (rdCyc[idx] != c0 + i * TICK) begin
        okAll = 0;
        check(0, "R6 read cycle", rdCyc[idx], c0 + i * TICK);
      end
    end
    check(okAll == 1, "R6 read pacing", okAll, 1);
    okAll = 1;
    for (int i = 0; i < effN && i < wrCnt - w0 && i < rdCnt - r0; i++) begin
      int wi;
      logic [DATA_W-1:0] exp;
      wi = (w0 + i) % 256;
      exp = ramWord((base + i) % (1 << ADDR_W));
      if (wrCyc[wi] != rdCyc[(r0 + i) % 256] + 1) begin
        okAll = 0;
        check(0, "R7 write follows read", wrCyc[wi], rdCyc[(r0 + i) % 256] + 1);
      end
      if (wrDat[wi] != exp) begin
        okAll = 0;
        check(0, disturb ? "R10 data" : "R5 data", int'(wrDat[wi]), int'(exp));
      end
    end
    check(okAll == 1, "R5 R7 words", okAll, 1);
    check(doneCnt - d0 == 1, "R8 done count", doneCnt - d0, 1);
    check(doneCyc == c0 + (effN - 1) * TICK + 2, "R8 done cycle", doneCyc, c0 + (effN - 1) * TICK + 2);
    check(doneLock == 1'b0, "R8 lock low at done", int'(doneLock), 0);
    check(hostLock == 1'b0, "R8 lock released", int'(hostLock), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(hostLock == 1'b0 && burstDone == 1'b0, "R1 reset outputs", int'({hostLock, burstDone}), 0);
    check(ramRdEn == 1'b0 && fifoWrEn == 1'b0, "R1 reset strobes", int'({ramRdEn, fifoWrEn}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(hostLock == 1'b0, "R1 lock after reset", int'(hostLock), 0);

    runBurst(1, 0, 2, 1'b0);            // R4 smallest burst
    runBurst(0, 50, 2, 1'b0);           // R4 zero means 32, R5 wrap
    runBurst(31, 63, 3, 1'b0);          // R5 wrap from top address
    runBurst(6, 10, 20, 1'b0);          // R2 long hold, no early launch
    runBurst(8, 20, 2, 1'b1);           // R9 R10 disturbance
    runBurst(0, 5, 2, 1'b1);            // R9 R10 on full burst
    for (int k = 0; k < 12; k++) begin
      runBurst(int'($urandom_range(0, 31)), int'($urandom_range(0, 63)),
               int'($urandom_range(1, 6)), 1'b0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCnt, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule